// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Read Latency

This block models a single-port synchronous static RAM for use inside a larger design. Address, write data, the two chip enables and the write controls are all captured on the rising clock edge. The output enable and the sleep input are not clocked: they gate the output as soon as they change. The read path has two settings. In flow-through mode the array word goes straight to the output in the cycle after the request is captured. In pipelined mode the word passes through one more output register first. A new command can be accepted on every clock.

Writes are masked by byte lane. A byte-write enable, together with one select bit per lane, updates only the chosen lanes. A global-write input updates the whole word and overrides the lane selects. The output is a data word plus a drive flag that stands in for a three-state bus. A deselect passes through one register stage fewer than a read, so the drive flag drops in the cycle right after the deselect is captured, in either mode.

Top module: `ssram_core`

## Requirements
- R1: With `pipe_mode`=0, a read captured at rising edge k shows the addressed word on `rdata` with `rdrive`=1 from edge k until edge k+1, provided `oe`=1 and `sleep`=0.
- R2: With `pipe_mode`=1, a read captured at edge k shows its word from edge k+1, provided the command captured at edge k+1 is a selected one. After edge k itself, `rdrive` is still 0.
- R3: Reads issued on consecutive clocks deliver one word per clock, in request order, in both modes.
- R4: A cycle is a write when it is selected and `bw_en`=1 or `wr_all`=1. With `bw_en`=1 and `wr_all`=0, only the lanes whose `lane_sel` bit is 1 are written. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R5: A write with `bw_en`=1 and `lane_sel`=0 leaves the word unchanged. A selected cycle with `bw_en`=0 and `wr_all`=0 is a read and writes nothing, whatever `lane_sel` holds.
- R6: `wr_all`=1 writes every lane, whatever `bw_en` and `lane_sel` hold.
- R7: A cycle is selected only when `ce_n`=0 and `ce`=1. A deselect captured at edge k forces `rdrive`=0 from edge k, in both modes, even if a pipelined read result is pending.
- R8: `oe`=0 forces `rdrive`=0 at once, without a clock edge. Raising `oe` again restores the drive of the read still in progress.
- R9: `sleep`=1 forces `rdrive`=0 at once. A read or write sampled while `sleep`=1 is ignored, and the stored contents are kept.
- R10: After reset, `rdrive` is 0 and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = registered read output, 0 = flow-through; change only while deselected |
| addr | input | 6 | Word address |
| wdata | input | 18 | Write data |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| bw_en | input | 1 | Byte-write enable |
| lane_sel | input | 2 | Per-lane write select |
| wr_all | input | 1 | Global write of all lanes |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous low-power request, active high |
| rdata | output | 18 | Read data |
| rdrive | output | 1 | Output drive flag |

## Verification
The hardest case to reach is a pipelined read whose result is already in the output register when the next captured command is a deselect. The data is valid, yet it must never be driven. The bench sets this up on purpose: it issues a pipelined read and then drops `ce` on the very next clock. A related hard case is a read sampled while sleep is high. The sleep input is released between clock edges, just after that read is captured, so the drive flag can only be wrong if the ignored read was latched anyway.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // Classify the sampled control inputs of one clock.
  function automatic cmd_e decode_cmd(input logic sleep, input logic ce_n,
                                      input logic ce, input logic wr_all,
                                      input logic bw_en);
    if (sleep || ce_n || !ce) return CMD_NONE;
    if (wr_all || bw_en) return CMD_WRITE;
    return CMD_READ;
  endfunction

  // Lane write mask: global write overrides the per-lane selects.
  function automatic logic [7:0] lane_mask(input logic is_write, input logic wr_all,
                                           input logic [7:0] sel, input int lanes);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++)
      if (i < lanes) m[i] = is_write && (wr_all || sel[i]);
    return m;
  endfunction
endpackage

// File: rtl/ssram_capture.sv
`timescale 1ns/1ps
module ssram_capture
  import ssram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ce_n,
  input  logic             ce,
  input  logic             wr_all,
  input  logic             bw_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic             sleep,
  output logic [LANES-1:0] wr_lanes,
  output logic             s1_sel,
  output logic             s1_rd,
  output logic [AW-1:0]    s1_addr
);
  cmd_e       cmd_now;
  logic [7:0] sel_wide;
  logic [7:0] mask_wide;

  assign cmd_now   = decode_cmd(sleep, ce_n, ce, wr_all, bw_en);
  assign sel_wide  = 8'(lane_sel);
  assign mask_wide = lane_mask(cmd_now == CMD_WRITE, wr_all, sel_wide, LANES);
  assign wr_lanes  = mask_wide[LANES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sel  <= 1'b0;
      s1_rd   <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_sel  <= (cmd_now != CMD_NONE);
      s1_rd   <= (cmd_now == CMD_READ);
      s1_addr <= addr;
    end
  end

  // R9: a command sampled during sleep never reaches the first stage
  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_sel);
  // R9: no lane is written while sleep is high
  a_r9_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (wr_lanes == '0));
  // R6: global write on a selected awake cycle enables every lane
  a_r6_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all && !ce_n && ce && !sleep) |-> (&wr_lanes));
endmodule

// File: rtl/ssram_array.sv
`timescale 1ns/1ps
module ssram_array #(
  parameter int AW    = 6,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (wr_lanes[g]) begin
        store[wr_addr] <= wdata[g*LW +: LW];
      end
    end

    assign rd_data[g*LW +: LW] = store[rd_addr];
  end
endmodule

// File: rtl/ssram_outstage.sv
`timescale 1ns/1ps
module ssram_outstage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic [DW-1:0] rd_data,
  input  logic          s1_sel,
  input  logic          s1_rd,
  input  logic          oe,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          rdrive
);
  logic [DW-1:0] q_data;
  logic          q_vld;
  logic          data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_vld  <= 1'b0;
    end else begin
      q_data <= rd_data;
      q_vld  <= s1_rd;
    end
  end

  // Deselect is taken from the first stage in both modes (one stage short).
  assign data_ok = pipe_mode ? q_vld : s1_rd;
  assign rdata   = pipe_mode ? q_data : rd_data;
  assign rdrive  = oe && !sleep && s1_sel && data_ok;
endmodule

// File: rtl/ssram_core.sv
`timescale 1ns/1ps
module ssram_core #(
  parameter int AW    = 6,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             ce_n,
  input  logic             ce,
  input  logic             bw_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic             wr_all,
  input  logic             oe,
  input  logic             sleep,
  output logic [DW-1:0]    rdata,
  output logic             rdrive
);
  logic [LANES-1:0] wr_lanes;
  logic             s1_sel;
  logic             s1_rd;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    arr_q;

  ssram_capture #(.AW(AW), .LANES(LANES)) u_capture (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce(ce),
    .wr_all(wr_all), .bw_en(bw_en), .lane_sel(lane_sel), .sleep(sleep),
    .wr_lanes(wr_lanes), .s1_sel(s1_sel), .s1_rd(s1_rd), .s1_addr(s1_addr)
  );

  ssram_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_addr(addr), .wdata(wdata),
    .wr_lanes(wr_lanes), .rd_addr(s1_addr), .rd_data(arr_q)
  );

  ssram_outstage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .rd_data(arr_q),
    .s1_sel(s1_sel), .s1_rd(s1_rd), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rdrive(rdrive)
  );

  // R1: a captured flow-through read is driven while enabled and awake
  a_r1_flow_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && s1_rd && oe && !sleep) |-> rdrive);
  // R2: in pipelined mode drive implies a read was captured one edge earlier
  a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rdrive) |-> $past(s1_rd));
  // R7: a deselect captured at an edge silences the output after it
  a_r7_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_n || !ce) && !sleep) |=> !rdrive);
  // R8: output enable low always removes drive
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rdrive);
endmodule

// File: tb/test_ssram_core.sv
`timescale 1ns/1ps
module test_ssram_core;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int LN = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ce_n = 1'b1;
  logic          ce = 1'b0;
  logic          bw_en = 1'b0;
  logic [LN-1:0] lane_sel = '0;
  logic          wr_all = 1'b0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdrive;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model [1<<AW];

  always #2.5 clk = ~clk;

  ssram_core i_ssram_core (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .addr(addr), .wdata(wdata),
    .ce_n(ce_n), .ce(ce), .bw_en(bw_en), .lane_sel(lane_sel), .wr_all(wr_all),
    .oe(oe), .sleep(sleep), .rdata(rdata), .rdrive(rdrive)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_idle();
    ce_n = 1'b1; ce = 1'b0; bw_en = 1'b0; wr_all = 1'b0; lane_sel = '0;
  endtask

  task automatic set_read(input logic [AW-1:0] a);
    ce_n = 1'b0; ce = 1'b1; bw_en = 1'b0; wr_all = 1'b0; addr = a;
  endtask

  // Drive a write and update the model by the requirements R4..R6.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic be, input logic [LN-1:0] ls, input logic ga);
    ce_n = 1'b0; ce = 1'b1; addr = a; wdata = d; bw_en = be; lane_sel = ls; wr_all = ga;
    if (!sleep) begin
      if (ga) model[a] = d;
      else if (be) begin
        if (ls[0]) model[a][8:0]  = d[8:0];
        if (ls[1]) model[a][17:9] = d[17:9];
      end
    end
    tick();
  endtask

  task automatic flow_read_check(input logic [AW-1:0] a, input string req);
    set_read(a);
    tick();
    check(rdrive === 1'b1, req, 32'(rdrive), 32'd1);
    check(rdata === model[a], req, 32'(rdata), 32'(model[a]));
  endtask

  task automatic t_reset();
    check(rdrive === 1'b0, "R10 drive after reset", 32'(rdrive), 32'd0);
    flow_read_check(6'd9, "R10 zero contents");
    set_idle(); tick();
  endtask

  task automatic t_lanes();
    do_write(6'd5, 18'h25A5A, 1'b0, 2'b00, 1'b1);
    flow_read_check(6'd5, "R6 global write");
    do_write(6'd5, 18'h3FFFF, 1'b1, 2'b01, 1'b0);
    flow_read_check(6'd5, "R4 lane0 only");
    do_write(6'd5, 18'h00000, 1'b1, 2'b10, 1'b0);
    flow_read_check(6'd5, "R4 lane1 only");
    do_write(6'd5, 18'h12345, 1'b1, 2'b00, 1'b0);
    flow_read_check(6'd5, "R5 no lane selected");
    wdata = 18'h3C3C3; lane_sel = 2'b11;
    flow_read_check(6'd5, "R5 selects without enable");
    lane_sel = '0;
    do_write(6'd5, 18'h1ABCD, 1'b1, 2'b01, 1'b1);
    flow_read_check(6'd5, "R6 global overrides selects");
    set_idle(); tick();
  endtask

  task automatic t_pipe_stream();
    logic [AW-1:0] al [4];
    al[0] = 6'd10; al[1] = 6'd11; al[2] = 6'd40; al[3] = 6'd63;
    for (int i = 0; i < 4; i++) do_write(al[i], 18'(32'h1F00 + 32'(i) * 32'h1111), 1'b0, 2'b00, 1'b1);
    set_idle(); tick();
    pipe_mode = 1'b1;
    tick();
    for (int i = 0; i < 5; i++) begin
      set_read(al[i % 4]);
      tick();
      if (i == 0) check(rdrive === 1'b0, "R2 not yet after first edge", 32'(rdrive), 32'd0);
      else begin
        check(rdrive === 1'b1, "R3 pipelined stream drive", 32'(rdrive), 32'd1);
        check(rdata === model[al[i-1]], "R2 R3 pipelined stream data",
              32'(rdata), 32'(model[al[i-1]]));
      end
    end
    set_idle(); tick();
  endtask

  task automatic t_flow_stream();
    pipe_mode = 1'b0;
    tick();
    for (int i = 0; i < 3; i++) flow_read_check(6'(10 + i), "R3 flow stream");
    set_idle(); tick();
  endtask

  task automatic t_deselect();
    pipe_mode = 1'b1; tick();
    set_read(6'd10); tick();
    ce = 1'b0; tick();
    check(rdrive === 1'b0, "R7 pipelined read then deselect", 32'(rdrive), 32'd0);
    set_idle(); pipe_mode = 1'b0; tick();
    set_read(6'd11); tick();
    ce_n = 1'b1; tick();
    check(rdrive === 1'b0, "R7 flow deselect by ce_n", 32'(rdrive), 32'd0);
    set_idle(); tick();
  endtask

  task automatic t_oe();
    flow_read_check(6'd40, "R1 flow read");
    oe = 1'b0; #1;
    check(rdrive === 1'b0, "R8 oe low async", 32'(rdrive), 32'd0);
    oe = 1'b1; #1;
    check(rdrive === 1'b1, "R8 oe restored", 32'(rdrive), 32'd1);
    set_idle(); tick();
  endtask

  task automatic t_sleep();
    logic [DW-1:0] old;
    old = model[6'd63];
    flow_read_check(6'd63, "R1 before sleep");
    sleep = 1'b1; #1;
    check(rdrive === 1'b0, "R9 sleep async off", 32'(rdrive), 32'd0);
    do_write(6'd63, 18'h00001, 1'b0, 2'b00, 1'b1);
    set_read(6'd63); tick();
    sleep = 1'b0; #1;
    check(rdrive === 1'b0, "R9 read during sleep ignored", 32'(rdrive), 32'd0);
    flow_read_check(6'd63, "R9 contents kept");
    check(rdata === old, "R9 write during sleep ignored", 32'(rdata), 32'(old));
    set_idle(); tick();
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) model[i] = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_lanes();
    t_pipe_stream();
    t_flow_stream();
    t_deselect();
    t_oe();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule